// File: doc/BRIEF.md
# Address Match Breakpoint Interrupt Unit

This unit sits beside the decode stage of a small processor. It raises a breakpoint-style request in the cycle just before an instruction at a programmed address would execute. It has two comparator channels. Each channel holds its own match address and its own enable bit. Both channels share one interrupt vector, so a sticky status field records which channel fired. Software reads that field and clears it by writing ones to it.

For each decode slot the decode stage presents four things: a valid strobe, the start address of the instruction, a two-bit length class, and a flag that marks the first instruction of a handler. A match counts only on a true instruction start. It is never gated by an interrupt mask or a priority level. The unit then pulses the request for one cycle and registers the address to be stacked. That address is not a return address. It is the matched address plus one or plus two, chosen by the length class.

Top module: `bkpt_match_unit`

## Requirements
- R1: A channel hits when its enable bit is 1, `dec_valid` is 1 and `dec_addr` equals its match address; a channel whose enable bit is 0 never hits, and no mask or priority input exists that could block a hit.
- R2: After reset the match addresses, the enable register, `match_status`, `irq_req` and `push_addr` are all zero, so no request can occur until software sets an enable bit.
- R3: `irq_req` is 1 for exactly the one cycle that follows each decode cycle in which at least one channel hits, and it is 0 in every other cycle.
- R4: Only length class 01 (plus-1 group) and 10 (plus-2 group) mark an instruction start; class 00 (mid-instruction or data) and class 11 never produce a hit.
- R5: A decode with `dec_isr_first` = 1 never produces a hit, even when its address equals an enabled match address.
- R6: Together with each request, `push_addr` becomes the matched address plus 2 for class 10 and plus 1 for class 01. It keeps that value until the next request.
- R7: A hit sets a sticky bit in `match_status`: bit 0 for channel 0 and bit 1 for channel 1. When both channels hit in the same cycle, only bit 0 is set.
- R8: A write with `wr_sel` = 3 clears each `match_status` bit whose `wr_data` bit is 1 and leaves bits written with 0 untouched. A set in the same cycle overrides the clear.
- R9: A write with `wr_sel` = 0 or 1 loads channel 0 or channel 1's match address from `wr_data`. A write with `wr_sel` = 2 loads the enables from `wr_data[1:0]`. A decode in the same cycle as a write is compared against the old contents.
- R10: The stacked address wraps modulo 2^ADDR_W, so a class 10 match at the top address yields 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 match0, 1 match1, 2 enables, 3 status clear |
| wr_data | input | 20 | Register write data |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_addr | input | 20 | Instruction start address |
| dec_len | input | 2 | Length class: 00 none, 01 plus-1, 10 plus-2, 11 none |
| dec_isr_first | input | 1 | Instruction is the first of a handler |
| irq_req | output | 1 | One-cycle breakpoint request |
| push_addr | output | 20 | Address to stack with the request |
| match_status | output | 2 | Sticky per-channel match flags |

## Verification
Two events can fall in the same cycle: a channel setting its status bit, and a software write that clears the same bit. The bench provokes this on purpose. It issues a status-clear write in the cycle where an enabled channel matches a decode, and it then expects the bit to remain set. The random phase mixes clear writes with decodes aimed at the programmed addresses, so the two events also collide by chance. A bench model judges every such cycle, with set taking precedence over clear. A second collision, a match-register write in the same cycle as a decode, is also driven. It is judged against the old register contents.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic [1:0] {
    LEN_NONE  = 2'b00,
    LEN_PLUS1 = 2'b01,
    LEN_PLUS2 = 2'b10,
    LEN_RSVD  = 2'b11
  } len_cls_e;

  typedef enum logic [1:0] {
    SEL_MATCH0 = 2'd0,
    SEL_MATCH1 = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  // true when the class marks the first byte of an instruction
  function automatic logic is_insn_start(input logic [1:0] cls);
    return (cls == LEN_PLUS1) || (cls == LEN_PLUS2);
  endfunction

  // amount added to the matched address before stacking
  function automatic logic [1:0] push_offset(input logic [1:0] cls);
    return (cls == LEN_PLUS2) ? 2'd2 : 2'd1;
  endfunction

  // keeps only the lowest set bit (channel 0 wins)
  function automatic logic [NCH-1:0] lowest_hit(input logic [NCH-1:0] v);
    return v & (~v + NCH'(1));
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [NCH-1:0]    set_vec,
  output logic [ADDR_W-1:0] match_addr [NCH],
  output logic [NCH-1:0]    en_q,
  output logic [NCH-1:0]    status_q
);
  logic [NCH-1:0] clr_vec;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           match_addr[ch] <= '0;
      else if (wr_en && wr_sel == 2'(ch))   match_addr[ch] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             en_q <= '0;
    else if (wr_en && wr_sel == SEL_ENABLE) en_q <= wr_data[NCH-1:0];
  end

  assign clr_vec = (wr_en && wr_sel == SEL_STATUS) ? wr_data[NCH-1:0] : '0;

  // set has precedence over a same-cycle write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              enable,
  input  logic              start_ok,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [ADDR_W-1:0] dec_addr,
  output logic              hit
);
  assign hit = enable && start_ok && (dec_addr == ref_addr);
endmodule

// File: rtl/bkpt_req.sv
module bkpt_req
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_hit,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [1:0]        dec_len,
  output logic [NCH-1:0]    set_vec,
  output logic              irq_req,
  output logic [ADDR_W-1:0] push_addr
);
  logic              any_hit;
  logic [ADDR_W-1:0] push_next;

  assign any_hit   = |ch_hit;
  assign set_vec   = lowest_hit(ch_hit);
  assign push_next = dec_addr + ADDR_W'(push_offset(dec_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      push_addr <= '0;
    end else begin
      irq_req <= any_hit;
      if (any_hit) push_addr <= push_next;
    end
  end
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [1:0]        dec_len,
  input  logic              dec_isr_first,
  output logic              irq_req,
  output logic [ADDR_W-1:0] push_addr,
  output logic [NCH-1:0]    match_status
);
  logic [ADDR_W-1:0] match_addr [NCH];
  logic [NCH-1:0]    en_q;
  logic [NCH-1:0]    ch_hit;
  logic [NCH-1:0]    set_vec;
  logic              start_ok;

  // qualifies the decode slot once for all channels
  assign start_ok = dec_valid && is_insn_start(dec_len) && !dec_isr_first;

  bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .set_vec    (set_vec),
    .match_addr (match_addr),
    .en_q       (en_q),
    .status_q   (match_status)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .enable   (en_q[ch]),
      .start_ok (start_ok),
      .ref_addr (match_addr[ch]),
      .dec_addr (dec_addr),
      .hit      (ch_hit[ch])
    );
  end

  bkpt_req #(.ADDR_W(ADDR_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_hit    (ch_hit),
    .dec_addr  (dec_addr),
    .dec_len   (dec_len),
    .set_vec   (set_vec),
    .irq_req   (irq_req),
    .push_addr (push_addr)
  );
endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_isr_first,
  input logic [1:0]        dec_len,
  input logic [ADDR_W-1:0] dec_addr,
  input logic [1:0]        en_q,
  input logic [1:0]        ch_hit,
  input logic              irq_req,
  input logic [ADDR_W-1:0] push_addr,
  input logic [1:0]        match_status
);
  // R1
  off_chan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |-> !ch_hit[0]);
  // R3
  hit_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_hit != 2'b00) |=> irq_req);
  // R3
  no_hit_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_hit == 2'b00) |=> !irq_req);
  // R4
  non_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_len == 2'b00 || dec_len == 2'b11) |-> (ch_hit == 2'b00));
  // R5
  handler_first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_isr_first |-> (ch_hit == 2'b00));
  // R6
  push_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_hit != 2'b00) |=> push_addr == $past(dec_addr) + (($past(dec_len) == 2'b10) ? ADDR_W'(2) : ADDR_W'(1)));
  // R6
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> $stable(push_addr));
  // R7
  both_hit_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_hit == 2'b11) |=> match_status[0]);
  // R8
  req_flags_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (match_status != 2'b00));
endmodule

bind bkpt_match_unit bkpt_match_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_isr_first (dec_isr_first),
  .dec_len       (dec_len),
  .dec_addr      (dec_addr),
  .en_q          (en_q),
  .ch_hit        (ch_hit),
  .irq_req       (irq_req),
  .push_addr     (push_addr),
  .match_status  (match_status)
);

// File: tb/test_bkpt_match_unit.sv
module test_bkpt_match_unit;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic          dec_valid = 1'b0;
  logic [AW-1:0] dec_addr = '0;
  logic [1:0]    dec_len = '0;
  logic          dec_isr_first = 1'b0;
  logic          irq_req;
  logic [AW-1:0] push_addr;
  logic [1:0]    match_status;

  int nchk = 0;
  int nerr = 0;

  // bench model state
  logic [AW-1:0] m_a0 = '0, m_a1 = '0, e_push = '0;
  logic [1:0]    m_en = '0, m_stat = '0;
  logic          e_irq = 1'b0;

  always #2 clk = ~clk;

  bkpt_match_unit #(.ADDR_W(AW)) i_bkpt_match_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dec_valid(dec_valid), .dec_addr(dec_addr), .dec_len(dec_len),
    .dec_isr_first(dec_isr_first), .irq_req(irq_req), .push_addr(push_addr),
    .match_status(match_status)
  );

  function automatic logic starts(input logic [1:0] c);
    return c[0] ^ c[1];
  endfunction

  function automatic logic [AW-1:0] stacked(input logic [AW-1:0] a, input logic [1:0] c);
    return (c == 2'b10) ? a + 20'd2 : a + 20'd1;
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  // one cycle: drive, clock, update model, compare at the falling edge
  task automatic cyc(input logic we, input logic [1:0] sel, input logic [AW-1:0] wd,
                     input logic v, input logic [AW-1:0] a, input logic [1:0] len,
                     input logic isr);
    logic h0, h1;
    logic [1:0] clr;
    wr_en = we; wr_sel = sel; wr_data = wd;
    dec_valid = v; dec_addr = a; dec_len = len; dec_isr_first = isr;
    @(posedge clk);
    h0 = m_en[0] && v && a == m_a0 && starts(len) && !isr;
    h1 = m_en[1] && v && a == m_a1 && starts(len) && !isr;
    e_irq = h0 | h1;
    if (e_irq) e_push = stacked(a, len);
    clr = (we && sel == 2'd3) ? wd[1:0] : 2'b00;
    m_stat = (m_stat & ~clr) | (h0 ? 2'b01 : (h1 ? 2'b10 : 2'b00));
    if (we && sel == 2'd0) m_a0 = wd;
    if (we && sel == 2'd1) m_a1 = wd;
    if (we && sel == 2'd2) m_en = wd[1:0];
    @(negedge clk);
    check(AW'(irq_req), AW'(e_irq), "R3 irq_req");
    check(push_addr, e_push, "R6 push_addr");
    check(AW'(match_status), AW'(m_stat), "R7 match_status");
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] wd);
    cyc(1'b1, sel, wd, 1'b0, '0, 2'b00, 1'b0);
  endtask

  task automatic dec(input logic [AW-1:0] a, input logic [1:0] len, input logic isr);
    cyc(1'b0, 2'd0, '0, 1'b1, a, len, isr);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R3: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R2 reset state
    check(AW'(irq_req), '0, "R2 reset irq");
    check(push_addr, '0, "R2 reset push");
    check(AW'(match_status), '0, "R2 reset status");
    rst_n = 1'b1;
    @(negedge clk);
    dec(20'h00000, 2'b01, 1'b0);
    check(AW'(irq_req), '0, "R2 no request while enables are zero");

    // R9 program both channels and enable them
    wr(2'd0, 20'h12345);
    wr(2'd1, 20'h00F00);
    wr(2'd2, 20'h00003);
    // R1 R6 plus-2 class on channel 0
    dec(20'h12345, 2'b10, 1'b0);
    check(AW'(irq_req), 20'd1, "R1 channel 0 request");
    check(push_addr, 20'h12347, "R6 plus-2 stacked address");
    check(AW'(match_status), 20'd1, "R7 channel 0 flag");
    dec(20'h12346, 2'b10, 1'b0);
    check(AW'(irq_req), '0, "R3 single-cycle pulse");
    check(push_addr, 20'h12347, "R6 held stacked address");
    dec(20'h00F00, 2'b01, 1'b0);
    check(push_addr, 20'h00F01, "R6 plus-1 stacked address");
    check(AW'(match_status), 20'd3, "R7 both flags sticky");
    // R8 partial and full clear
    wr(2'd3, 20'h00002);
    check(AW'(match_status), 20'd1, "R8 clear bit 1 only");
    wr(2'd3, 20'h00001);
    check(AW'(match_status), '0, "R8 clear bit 0");
    // R4 non-start classes
    dec(20'h12345, 2'b00, 1'b0);
    check(AW'(irq_req), '0, "R4 class 00 ignored");
    dec(20'h12345, 2'b11, 1'b0);
    check(AW'(irq_req), '0, "R4 class 11 ignored");
    // R5 first handler instruction
    dec(20'h12345, 2'b10, 1'b1);
    check(AW'(irq_req), '0, "R5 handler first ignored");
    check(AW'(match_status), '0, "R5 status untouched");
    // R7 both channels on one address
    wr(2'd1, 20'h12345);
    dec(20'h12345, 2'b01, 1'b0);
    check(AW'(match_status), 20'd1, "R7 channel 0 priority");
    // R8 set beats same-cycle clear
    cyc(1'b1, 2'd3, 20'h00001, 1'b1, 20'h12345, 2'b01, 1'b0);
    check(AW'(match_status), 20'd1, "R8 set wins over clear");
    wr(2'd3, 20'h00003);
    // R9 decode sees old match value during a write
    cyc(1'b1, 2'd0, 20'h0ABCD, 1'b1, 20'h12345, 2'b10, 1'b0);
    check(AW'(irq_req), 20'd1, "R9 old value compared");
    dec(20'h0ABCD, 2'b10, 1'b0);
    check(AW'(irq_req), 20'd1, "R9 new value active");
    // R10 wrap at top of address space
    wr(2'd0, 20'hFFFFF);
    dec(20'hFFFFF, 2'b10, 1'b0);
    check(push_addr, 20'h00001, "R10 wrapped stacked address");
    // R1 disabled channel 0
    wr(2'd2, 20'h00002);
    wr(2'd3, 20'h00003);
    dec(20'hFFFFF, 2'b10, 1'b0);
    check(AW'(irq_req), '0, "R1 disabled channel silent");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [1:0] sel, len;
      logic [AW-1:0] wd, a;
      we  = ($urandom % 6) == 0;
      sel = 2'($urandom);
      wd  = (sel == 2'd2) ? 20'($urandom % 4) :
            (($urandom % 4) == 0) ? 20'hFFFFF : 20'($urandom % 64);
      case ($urandom % 3)
        0: a = m_a0;
        1: a = m_a1;
        default: a = 20'($urandom % 64);
      endcase
      len = 2'($urandom);
      cyc(we, sel, wd, ($urandom % 5) != 0, a, len, ($urandom % 8) == 0);
    end

    summary();
    $finish;
  end
endmodule